// File: doc/BRIEF.md
# Vectored Interrupt Controller with Global Enable

This block gathers a parameterised set of interrupt sources and turns them into a single vector request for a simple CPU sequencer. Each source is configured as edge-type or level-type by a parameter bit vector. An edge-type source latches a pending flag on a rising edge of its input. A level-type source requests only while its input is high. Every source has its own enable bit, and a global enable gates all of them. The lowest-numbered source that is eligible wins.

Once a request is raised, it is held with a stable index until the CPU accepts it. On acceptance the block clears that source's pending flag and the global enable, then reports the cycles spent on the entry sequence (the return-address push). A return strobe sets the global enable again and reports the return-sequence cycles (the pop). After a global-enable set or a return, one instruction has to retire before any request is taken. A global-enable clear blocks requests at once. The CPU datapath and the stack memory live outside the block; only their cycle counts appear here.

Top module: `vic_core`

## Requirements
- R1: After reset, all pending flags, all per-source enables and the global enable are zero, and `irq_req`, `entry_busy` and `ret_busy` are low. With enables at zero, a source event raises no request.
- R2: When several sources are pending and enabled, `irq_idx` gives the binary index of the lowest-numbered one. A disabled source is passed over in favour of the next enabled one.
- R3: For an edge-type source (its bit in `LEVEL_MASK` is 0), a 0-to-1 change on `src_in[i]` sets its pending flag. The flag stays set while that source's enable or the global enable is off, and a request follows once both are on.
- R4: When `clr_wr` is high, each pending flag whose bit in `clr_mask` is 1 is cleared. If a rising edge on the same source arrives in the same cycle, the edge wins and the flag stays set.
- R5: A level-type source (its bit in `LEVEL_MASK` is 1) stores nothing. It requests only while `src_in[i]` is high and the source is enabled, so a level that drops before the global enable comes on leaves no request.
- R6: `irq_req` rises one clock after the winning request becomes eligible. It then stays high with a stable `irq_idx` until `irq_ack`. Acceptance clears the winner's pending flag and the global enable.
- R7: After the clock that accepts a request, `entry_busy` is high for exactly `ENTRY_CYC` (4) cycles. If `sleep_in` is high in the accepting cycle, it is high for `ENTRY_CYC+SLEEP_EXTRA` (8) cycles instead.
- R8: A `gie_clr` pulse takes effect in its own cycle. No request is raised from that cycle onwards, even one from a level source that rises in the same cycle.
- R9: After a `gie_set` pulse, no request is raised until an `insn_ret` pulse arrives in a later cycle than the set.
- R10: A `reti` pulse while the sequencer is idle holds `ret_busy` high for exactly `RETURN_CYC` (4) cycles and sets the global enable. A pending request then waits for an `insn_ret` pulse that arrives after `ret_busy` has fallen; retirements during the return sequence do not count.
- R11: Setting the global enable inside a handler, after entry, lets a new request be raised (nesting). A source already vectored is not raised again without a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Source inputs: edges for edge-type sources, conditions for level-type sources |
| clr_wr | input | 1 | Write strobe for write-one-to-clear of pending flags |
| clr_mask | input | NUM_SRC | Pending flags to clear when `clr_wr` is high |
| en_wr | input | 1 | Write strobe for the per-source enable register |
| en_data | input | NUM_SRC | New value of the per-source enables |
| gie_set | input | 1 | Set-global-enable command |
| gie_clr | input | 1 | Clear-global-enable command |
| reti | input | 1 | Return-from-interrupt strobe |
| insn_ret | input | 1 | Instruction-retired strobe |
| sleep_in | input | 1 | Core is asleep; extends the entry sequence |
| irq_ack | input | 1 | CPU accepts the current vector request |
| irq_req | output | 1 | Vector request |
| irq_idx | output | $clog2(NUM_SRC) | Index of the requested vector |
| entry_busy | output | 1 | Entry sequence in progress |
| ret_busy | output | 1 | Return sequence in progress |

## Verification
The bench sweeps every non-empty combination of the six edge-type sources in its configuration. In each case it expects the lowest set index, so a reversed or off-by-one priority chain shows up straight away. It also goes after the single-cycle orderings:
- A retirement in the same cycle as the enable set, or during the return sequence, must not release the hold; a design that counted either would vector one instruction early.
- A level input that rises together with a clear-global command must not leak through; a design that registered the clear would raise one request.
- A flag edge that coincides with a write-one-to-clear must survive; a design that let the clear win would lose an interrupt.
- Entry lengths are measured both awake and asleep, so a design that sampled the sleep input in the wrong cycle would report the wrong count.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_REQ,
        SEQ_ENTRY,
        SEQ_RET
    } seq_state_e;

    // Length of the entry sequence, with the extra wake-up cycles when asleep.
    function automatic int unsigned entry_len(input logic asleep,
                                              input int unsigned base,
                                              input int unsigned extra);
        return asleep ? base + extra : base;
    endfunction

endpackage

// File: rtl/vic_flags.sv
module vic_flags #(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] clr_mask,
    input  logic               en_wr,
    input  logic [NUM_SRC-1:0] en_data,
    input  logic [NUM_SRC-1:0] vec_clr,
    output logic [NUM_SRC-1:0] cand
);
    localparam logic [NUM_SRC-1:0] EDGE_MASK = ~LEVEL_MASK;

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] kill;
    logic [NUM_SRC-1:0] pend_d;

    always_comb begin
        rise   = src_in & ~src_q & EDGE_MASK;
        kill   = ({NUM_SRC{clr_wr}} & clr_mask) | vec_clr;
        // a new edge outranks any clear in the same cycle
        pend_d = rise | (pend_q & ~kill);
        cand   = (pend_q | (src_in & LEVEL_MASK)) & en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            src_q  <= src_in;
            pend_q <= pend_d;
            if (en_wr) begin
                en_q <= en_data;
            end
        end
    end

endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    logic [NUM_SRC:0]   seen;
    logic [NUM_SRC-1:0] grant;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
        assign grant[i]  = cand[i] & ~seen[i];
        assign seen[i+1] = seen[i] | cand[i];
    end

    assign any = seen[NUM_SRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_seq.sv
module vic_seq
    import vic_pkg::*;
#(
    parameter int IDX_W       = 3,
    parameter int ENTRY_CYC   = 4,
    parameter int SLEEP_EXTRA = 4,
    parameter int RETURN_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_any,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             gie_set,
    input  logic             gie_clr,
    input  logic             reti,
    input  logic             insn_ret,
    input  logic             sleep_in,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [IDX_W-1:0] irq_idx,
    output logic             entry_busy,
    output logic             ret_busy,
    output logic             vec_fire,
    output logic             gie_q,
    output logic             hold_q
);
    localparam int CNT_W = $clog2(ENTRY_CYC + SLEEP_EXTRA + RETURN_CYC + 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             idle;
    logic             take;
    logic             ret_start;
    logic             cnt_done;

    always_comb begin
        idle      = (state_q == SEQ_IDLE);
        ret_start = idle & reti;
        take      = idle & req_any & gie_q & ~hold_q & ~gie_clr & ~gie_set & ~reti;
        cnt_done  = (cnt_q == '0);
        vec_fire  = (state_q == SEQ_REQ) & irq_ack;
    end

    assign irq_req    = (state_q == SEQ_REQ);
    assign irq_idx    = idx_q;
    assign entry_busy = (state_q == SEQ_ENTRY);
    assign ret_busy   = (state_q == SEQ_RET);

    // global enable and the one-instruction hold
    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (gie_clr) begin
                gie_q <= 1'b0;
            end else if (vec_fire) begin
                gie_q <= 1'b0;
            end else if (gie_set | ret_start) begin
                gie_q <= 1'b1;
            end
            if (gie_set | ret_start) begin
                hold_q <= 1'b1;
            end else if (insn_ret & idle) begin
                hold_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (ret_start) begin
                        state_q <= SEQ_RET;
                        cnt_q   <= CNT_W'(RETURN_CYC - 1);
                    end else if (take) begin
                        state_q <= SEQ_REQ;
                        idx_q   <= req_idx;
                    end
                end
                SEQ_REQ: begin
                    if (irq_ack) begin
                        state_q <= SEQ_ENTRY;
                        cnt_q   <= CNT_W'(entry_len(sleep_in, ENTRY_CYC, SLEEP_EXTRA) - 1);
                    end
                end
                SEQ_ENTRY, SEQ_RET: begin
                    if (cnt_done) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vic_core.sv
module vic_core #(
    parameter int NUM_SRC     = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
    parameter int ENTRY_CYC   = 4,
    parameter int SLEEP_EXTRA = 4,
    parameter int RETURN_CYC  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         src_in,
    input  logic                       clr_wr,
    input  logic [NUM_SRC-1:0]         clr_mask,
    input  logic                       en_wr,
    input  logic [NUM_SRC-1:0]         en_data,
    input  logic                       gie_set,
    input  logic                       gie_clr,
    input  logic                       reti,
    input  logic                       insn_ret,
    input  logic                       sleep_in,
    input  logic                       irq_ack,
    output logic                       irq_req,
    output logic [$clog2(NUM_SRC)-1:0] irq_idx,
    output logic                       entry_busy,
    output logic                       ret_busy
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] vec_clr;
    logic               req_any;
    logic [IDX_W-1:0]   req_idx;
    logic               vec_fire;
    logic               gie_q;
    logic               hold_q;

    assign vec_clr = vec_fire ? (NUM_SRC'(1) << irq_idx) : '0;

    vic_flags #(
        .NUM_SRC   (NUM_SRC),
        .LEVEL_MASK(LEVEL_MASK)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .src_in  (src_in),
        .clr_wr  (clr_wr),
        .clr_mask(clr_mask),
        .en_wr   (en_wr),
        .en_data (en_data),
        .vec_clr (vec_clr),
        .cand    (cand)
    );

    vic_arb #(
        .NUM_SRC(NUM_SRC)
    ) u_arb (
        .cand(cand),
        .any (req_any),
        .idx (req_idx)
    );

    vic_seq #(
        .IDX_W      (IDX_W),
        .ENTRY_CYC  (ENTRY_CYC),
        .SLEEP_EXTRA(SLEEP_EXTRA),
        .RETURN_CYC (RETURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_any   (req_any),
        .req_idx   (req_idx),
        .gie_set   (gie_set),
        .gie_clr   (gie_clr),
        .reti      (reti),
        .insn_ret  (insn_ret),
        .sleep_in  (sleep_in),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req),
        .irq_idx   (irq_idx),
        .entry_busy(entry_busy),
        .ret_busy  (ret_busy),
        .vec_fire  (vec_fire),
        .gie_q     (gie_q),
        .hold_q    (hold_q)
    );

endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
    parameter int IDX_W       = 3,
    parameter int ENTRY_CYC   = 4,
    parameter int SLEEP_EXTRA = 4,
    parameter int RETURN_CYC  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             gie_clr,
    input logic             irq_ack,
    input logic             irq_req,
    input logic [IDX_W-1:0] irq_idx,
    input logic             entry_busy,
    input logic             ret_busy,
    input logic             sleep_in,
    input logic             gie_q,
    input logic             hold_q
);
    int unsigned entry_run;
    int unsigned ret_run;
    logic        slept;

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_run <= 0;
            ret_run   <= 0;
            slept     <= 1'b0;
        end else begin
            entry_run <= entry_busy ? entry_run + 1 : 0;
            ret_run   <= ret_busy ? ret_run + 1 : 0;
            if (irq_req && irq_ack) begin
                slept <= sleep_in;
            end
        end
    end

    // R6: request held with stable index until accepted
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_idx)));

    // R6: acceptance drops the global enable and starts entry
    assert_ack_drops_gie_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> (!gie_q && entry_busy));

    // R8: clear-global blocks a request in its own cycle
    assert_clr_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (gie_clr && !irq_req) |=> !irq_req);

    // R9: a new request needs the global enable with the hold released
    assert_take_needs_gie_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> ($past(gie_q) && !$past(hold_q)));

    // R7: entry sequence length, awake or asleep
    assert_entry_len_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(entry_busy) |-> (entry_run == (slept ? ENTRY_CYC + SLEEP_EXTRA : ENTRY_CYC)));

    // R10: return sequence length
    assert_ret_len_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(ret_busy) |-> (ret_run == RETURN_CYC));

endmodule

bind vic_core vic_core_chk #(
    .IDX_W      ($clog2(NUM_SRC)),
    .ENTRY_CYC  (ENTRY_CYC),
    .SLEEP_EXTRA(SLEEP_EXTRA),
    .RETURN_CYC (RETURN_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gie_clr   (gie_clr),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_idx   (irq_idx),
    .entry_busy(entry_busy),
    .ret_busy  (ret_busy),
    .sleep_in  (sleep_in),
    .gie_q     (gie_q),
    .hold_q    (hold_q)
);

// File: tb/sim_vic_core.sv
`timescale 1ns/1ps
module sim_vic_core;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src_in = '0;
    logic         clr_wr = 1'b0;
    logic [N-1:0] clr_mask = '0;
    logic         en_wr = 1'b0;
    logic [N-1:0] en_data = '0;
    logic         gie_set = 1'b0;
    logic         gie_clr = 1'b0;
    logic         reti = 1'b0;
    logic         insn_ret = 1'b0;
    logic         sleep_in = 1'b0;
    logic         irq_ack = 1'b0;
    logic         irq_req;
    logic [2:0]   irq_idx;
    logic         entry_busy;
    logic         ret_busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vic_core #(
        .NUM_SRC    (N),
        .LEVEL_MASK (8'hC0),
        .ENTRY_CYC  (4),
        .SLEEP_EXTRA(4),
        .RETURN_CYC (4)
    ) u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .en_wr(en_wr), .en_data(en_data), .gie_set(gie_set), .gie_clr(gie_clr),
        .reti(reti), .insn_ret(insn_ret), .sleep_in(sleep_in), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_idx(irq_idx), .entry_busy(entry_busy), .ret_busy(ret_busy)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lowest(input int m);
        for (int i = 0; i < N; i++) begin
            if (m[i]) return i;
        end
        return -1;
    endfunction

    task automatic pulse_src(input logic [N-1:0] m);
        src_in = m;
        tick();
        src_in = '0;
        tick();
    endtask

    // set global enable, then retire one instruction in the next cycle
    task automatic gie_on();
        gie_set = 1'b1;
        tick();
        gie_set = 1'b0;
        insn_ret = 1'b1;
        tick();
        insn_ret = 1'b0;
    endtask

    task automatic w1c(input logic [N-1:0] m);
        clr_wr = 1'b1;
        clr_mask = m;
        tick();
        clr_wr = 1'b0;
        clr_mask = '0;
    endtask

    task automatic ack_wait(input logic s, output int n);
        irq_ack = 1'b1;
        sleep_in = s;
        tick();
        irq_ack = 1'b0;
        sleep_in = 1'b0;
        n = 0;
        while (entry_busy && n < 30) begin
            n++;
            tick();
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 irq_req after reset", irq_req, 0);
        chk("R1 entry_busy after reset", entry_busy, 0);
        chk("R1 ret_busy after reset", ret_busy, 0);

        // enables are zero after reset: an edge raises nothing
        gie_on();
        pulse_src(8'h04);
        tick();
        chk("R1 no request with enables cleared", irq_req, 0);

        // the flag survived while disabled (R3)
        en_data = '1;
        en_wr = 1'b1;
        tick();
        en_wr = 1'b0;
        tick();
        chk("R3 retained flag requests", irq_req, 1);
        chk("R3 retained flag index", irq_idx, 2);
        repeat (3) tick();
        chk("R6 request held", irq_req, 1);
        chk("R6 index held", irq_idx, 2);
        ack_wait(1'b0, n);
        chk("R7 entry length awake", n, 4);

        // global enable is off after acceptance
        pulse_src(8'h08);
        tick();
        chk("R6 gie cleared by vectoring", irq_req, 0);

        // set without retirement holds the request back
        gie_set = 1'b1;
        tick();
        gie_set = 1'b0;
        repeat (3) tick();
        chk("R9 hold until retirement", irq_req, 0);
        insn_ret = 1'b1;
        tick();
        insn_ret = 1'b0;
        tick();
        chk("R9 request after retirement", irq_req, 1);
        chk("R9 index after retirement", irq_idx, 3);
        ack_wait(1'b1, n);
        chk("R7 entry length asleep", n, 8);

        // same-cycle set and retire does not release the hold
        gie_set = 1'b1;
        insn_ret = 1'b1;
        pulse_src(8'h02);
        gie_set = 1'b0;
        insn_ret = 1'b0;
        src_in = '0;
        tick();
        tick();
        chk("R9 same-cycle retire ignored", irq_req, 0);
        insn_ret = 1'b1;
        tick();
        insn_ret = 1'b0;
        tick();
        chk("R9 later retire releases", irq_idx, 1);
        chk("R9 later retire raises", irq_req, 1);
        ack_wait(1'b0, n);

        // vectored flags were cleared: nothing remains
        gie_on();
        tick();
        tick();
        chk("R11 vectored source not raised again", irq_req, 0);

        // return sequence
        gie_clr = 1'b1;
        tick();
        gie_clr = 1'b0;
        pulse_src(8'h10);
        reti = 1'b1;
        tick();
        reti = 1'b0;
        insn_ret = 1'b1;
        n = 0;
        while (ret_busy && n < 30) begin
            n++;
            tick();
        end
        insn_ret = 1'b0;
        chk("R10 return length", n, 4);
        tick();
        tick();
        chk("R10 retire during return ignored", irq_req, 0);
        insn_ret = 1'b1;
        tick();
        insn_ret = 1'b0;
        tick();
        chk("R10 request after return and retire", irq_req, 1);
        chk("R10 index after return", irq_idx, 4);
        ack_wait(1'b0, n);

        // nesting: re-enable inside the handler
        pulse_src(8'h20);
        chk("R11 blocked inside handler", irq_req, 0);
        gie_on();
        tick();
        chk("R11 nested request", irq_req, 1);
        chk("R11 nested index", irq_idx, 5);
        ack_wait(1'b0, n);

        // clear-global blocks a level arriving in the same cycle
        gie_on();
        src_in = 8'h40;
        gie_clr = 1'b1;
        tick();
        gie_clr = 1'b0;
        chk("R8 same-cycle level blocked", irq_req, 0);
        tick();
        chk("R8 stays blocked", irq_req, 0);
        src_in = '0;
        tick();
        gie_on();
        tick();
        chk("R5 level leaves no memory", irq_req, 0);
        src_in = 8'h40;
        tick();
        chk("R5 level requests", irq_req, 1);
        chk("R5 level index", irq_idx, 6);
        ack_wait(1'b0, n);
        gie_on();
        tick();
        chk("R5 level still high requests again", irq_idx, 6);
        chk("R5 level still high raises", irq_req, 1);
        ack_wait(1'b0, n);
        src_in = '0;
        tick();

        // write-one-to-clear
        pulse_src(8'h01);
        w1c(8'h01);
        gie_on();
        tick();
        tick();
        chk("R4 cleared flag gives nothing", irq_req, 0);
        gie_clr = 1'b1;
        tick();
        gie_clr = 1'b0;
        src_in = 8'h20;
        clr_wr = 1'b1;
        clr_mask = 8'h20;
        tick();
        src_in = '0;
        clr_wr = 1'b0;
        clr_mask = '0;
        tick();
        gie_on();
        tick();
        chk("R4 edge wins over clear", irq_req, 1);
        chk("R4 edge wins index", irq_idx, 5);
        ack_wait(1'b0, n);

        // disabled source is skipped
        en_data = 8'hFE;
        en_wr = 1'b1;
        tick();
        en_wr = 1'b0;
        pulse_src(8'h11);
        gie_on();
        tick();
        chk("R2 disabled lowest skipped", irq_idx, 4);
        ack_wait(1'b0, n);
        w1c('1);
        en_data = '1;
        en_wr = 1'b1;
        tick();
        en_wr = 1'b0;

        // priority sweep over all edge-source combinations
        for (int m = 1; m < 64; m++) begin
            pulse_src(8'(m));
            gie_on();
            tick();
            chk($sformatf("R2 priority mask %0d req", m), irq_req, 1);
            chk($sformatf("R2 priority mask %0d idx", m), irq_idx, lowest(m));
            ack_wait(1'b0, n);
            w1c('1);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule